// File: doc/BRIEF.md
# Passive Parallel Configuration Sequencer

This block is a hardware state machine that runs the host side of the handshake that puts a programmable logic device into passive-parallel configuration. A single start pulse launches the sequence. The sequencer first vets the mode-select strapping. It then waits until nobody else holds the configuration lines, takes control of the request and chip-enable drivers, and pulses the active-low request line while it follows the status line down and back up. After that it checks that the done pin is still low, opens the data and control paths, and waits for external streaming logic to report that the bitstream has been sent.

Once the data phase is over, it waits for the done pin and then for user mode. It then closes the data paths, hands the pins back by raising its override disables, and performs a final check on user-mode, done and status. Each wait is bounded by a cycle-count timeout. Each way the sequence can fail leaves its own error code, which stays visible until the next start. All pin inputs pass through a two-stage synchronizer before the state machine sees them.

Top module: `ppcfg_seq`

## Requirements
- R1: After reset: ceN=1, reqOut=1, dataEn=0, ctrlEn=0, prReq=0, statOe=0, doneOe=0, all four override disables =1, busy=0, cfgOk=0, errCode=0.
- R2: The first step after start checks modeSel. If any bit above bit 0 is set, the run ends with errCode=1 and no pin output changes. The values 0 and 1 are accepted.
- R3: Before it drives any pin, the sequencer waits until the synchronized request and status inputs both read 1. While they do not, ceN stays 1.
- R4: Setup drives ceN=1, prReq=0, dataEn=ctrlEn=0, reqOut=1, statOe=doneOe=0, cfgOvrDisN=reqOvrDisN=0 and statOvrDisN=doneOvrDisN=1. ceN goes low one cycle later, and then request and status are awaited again.
- R5: The reset handshake drives reqOut low until status reads 0, then drives reqOut high until status reads 1.
- R6: After the handshake, donePinIn must read 0 and doneOeIn must read 1. Otherwise the run ends with errCode=3.
- R7: dataEn and ctrlEn rise together, and only after a successful handshake. Any abort clears both.
- R8: After dataFinished, while the sequencer waits for done, status reading 0 before done is seen ends the run with errCode=4.
- R9: Every pin wait gives up after TMO_CYCLES+1 evaluated cycles without its condition, ending with errCode=2. The default limit is 1000 ms of clock cycles.
- R10: After user mode, the sequencer clears both enables, sets cfgOvrDisN and reqOvrDisN, and drives ceN=1. Then user-mode, done and status must all read 1: if they do, cfgOk=1; if not, errCode=5.
- R11: Pin inputs and modeSel reach the state machine through two flip-flops, so a pin change is acted on two cycles after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a sequence |
| modeSel | input | MSEL_W | Mode-select strapping |
| reqPinIn | input | 1 | Sampled level of the configuration request pin |
| statPinIn | input | 1 | Sampled level of the status pin |
| donePinIn | input | 1 | Sampled level of the done pin |
| doneOeIn | input | 1 | Device-side done output-enable level |
| userModeIn | input | 1 | Device reports user mode |
| dataFinished | input | 1 | Streaming logic has sent the whole bitstream |
| ceN | output | 1 | Active-low chip enable |
| prReq | output | 1 | Partial-reconfiguration request (held low) |
| reqOut | output | 1 | Active-low configuration request drive |
| statOe | output | 1 | Host output enable for status (held low) |
| doneOe | output | 1 | Host output enable for done (held low) |
| cfgOvrDisN | output | 1 | Override disable, configuration drivers |
| reqOvrDisN | output | 1 | Override disable, request driver |
| statOvrDisN | output | 1 | Override disable, status driver |
| doneOvrDisN | output | 1 | Override disable, done driver |
| dataEn | output | 1 | Data path enable |
| ctrlEn | output | 1 | Control/clock path enable |
| busy | output | 1 | A sequence is running |
| cfgOk | output | 1 | Last sequence completed successfully |
| errCode | output | 3 | 0 none, 1 mode, 2 timeout, 3 handshake, 4 status-low, 5 final check |

## Verification
The assertions assume that start is pulsed only while busy is low. They also assume that modeSel stays stable during a run, and that dataFinished is raised only once the enables are open. The bench uses a behavioural device model in which status follows the request drive after a short delay. Each scenario forces a single departure from that model: a held request pin, a missing done output-enable, status collapsing during the done wait or at user mode, or user mode that never arrives. Start is pulsed only from idle, and modeSel is changed only between runs.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;
  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_MODE      = 3'd1,
    ERR_TIMEOUT   = 3'd2,
    ERR_HANDSHAKE = 3'd3,
    ERR_STATLOW   = 3'd4,
    ERR_FINAL     = 3'd5
  } errCode_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CHKMODE, S_WREL1, S_SETUP, S_CELOW, S_WREL2, S_REQLO, S_WSTLO,
    S_REQHI, S_WSTHI, S_CHKDONE, S_ENABLE, S_WDATA, S_WCD, S_WUM, S_RELPINS,
    S_LASTCHK
  } state_e;

  typedef struct packed {
    logic     clrResult;
    logic     setup;
    logic     ceLow;
    logic     reqLow;
    logic     reqHigh;
    logic     enPaths;
    logic     relPins;
    logic     clrCnt;
    logic     incCnt;
    logic     finishOk;
    logic     abort;
    errCode_e code;
  } strobe_t;
endpackage

// File: rtl/ppcfg_sync.sv
module ppcfg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= '0;
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ppcfg_ctrl.sv
module ppcfg_ctrl
  import ppcfg_pkg::*;
#(
  parameter int MSEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MSEL_W-1:0] sMode,
  input  logic              sReq,
  input  logic              sStat,
  input  logic              sDone,
  input  logic              sDoe,
  input  logic              sUser,
  input  logic              dataFin,
  input  logic              cntHit,
  output strobe_t           stb,
  output logic              busy
);
  state_e st, nx;
  logic   isWait, waitCond;
  state_e waitTgt;

  always_comb begin
    nx       = st;
    stb      = '0;
    stb.code = ERR_NONE;
    stb.clrCnt = 1'b1;
    isWait   = 1'b0;
    waitCond = 1'b0;
    waitTgt  = S_IDLE;
    case (st)
      S_IDLE:    if (start) begin nx = S_CHKMODE; stb.clrResult = 1'b1; end
      S_CHKMODE: begin
        if (|sMode[MSEL_W-1:1]) begin
          stb.abort = 1'b1; stb.code = ERR_MODE; nx = S_IDLE;
        end else nx = S_WREL1;
      end
      S_WREL1:   begin isWait = 1'b1; waitCond = sReq && sStat; waitTgt = S_SETUP; end
      S_SETUP:   begin stb.setup = 1'b1; nx = S_CELOW; end
      S_CELOW:   begin stb.ceLow = 1'b1; nx = S_WREL2; end
      S_WREL2:   begin isWait = 1'b1; waitCond = sReq && sStat; waitTgt = S_REQLO; end
      S_REQLO:   begin stb.reqLow = 1'b1; nx = S_WSTLO; end
      S_WSTLO:   begin isWait = 1'b1; waitCond = !sStat; waitTgt = S_REQHI; end
      S_REQHI:   begin stb.reqHigh = 1'b1; nx = S_WSTHI; end
      S_WSTHI:   begin isWait = 1'b1; waitCond = sStat; waitTgt = S_CHKDONE; end
      S_CHKDONE: begin
        if (!sDone && sDoe) nx = S_ENABLE;
        else begin stb.abort = 1'b1; stb.code = ERR_HANDSHAKE; nx = S_IDLE; end
      end
      S_ENABLE:  begin stb.enPaths = 1'b1; nx = S_WDATA; end
      S_WDATA:   if (dataFin) nx = S_WCD;
      S_WCD: begin
        if (!sDone && !sStat) begin
          stb.abort = 1'b1; stb.code = ERR_STATLOW; nx = S_IDLE;
        end else begin
          isWait = 1'b1; waitCond = sDone; waitTgt = S_WUM;
        end
      end
      S_WUM:     begin isWait = 1'b1; waitCond = sUser; waitTgt = S_RELPINS; end
      S_RELPINS: begin stb.relPins = 1'b1; nx = S_LASTCHK; end
      S_LASTCHK: begin
        if (sUser && sDone && sStat) begin stb.finishOk = 1'b1; nx = S_IDLE; end
        else begin stb.abort = 1'b1; stb.code = ERR_FINAL; nx = S_IDLE; end
      end
      default:   nx = S_IDLE;
    endcase
    if (isWait) begin
      if (waitCond) nx = waitTgt;
      else if (cntHit) begin
        stb.abort = 1'b1; stb.code = ERR_TIMEOUT; nx = S_IDLE;
      end else begin
        stb.clrCnt = 1'b0; stb.incCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nx;
  end

  assign busy = (st != S_IDLE);

  AST_SETUP_AFTER_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_SETUP) |-> $past(sReq && sStat)); // R3
  AST_ENABLE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_ENABLE) |-> $past(!sDone && sDoe)); // R6
  AST_STATLOW_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_WCD && !sDone && !sStat) |=> (st == S_IDLE)); // R8
endmodule

// File: rtl/ppcfg_dp.sv
module ppcfg_dp
  import ppcfg_pkg::*;
#(
  parameter int TMO_CYCLES = 1000,
  localparam int CNT_W = $clog2(TMO_CYCLES + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  strobe_t  stb,
  output logic     cntHit,
  output logic     ceN,
  output logic     prReq,
  output logic     reqOut,
  output logic     statOe,
  output logic     doneOe,
  output logic     cfgOvrDisN,
  output logic     reqOvrDisN,
  output logic     statOvrDisN,
  output logic     doneOvrDisN,
  output logic     dataEn,
  output logic     ctrlEn,
  output logic     cfgOk,
  output errCode_e errCode
);
  logic [CNT_W-1:0] cnt;

  assign cntHit = (cnt == CNT_W'(TMO_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (stb.clrCnt) cnt <= '0;
    else if (stb.incCnt) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceN <= 1'b1; prReq <= 1'b0; reqOut <= 1'b1; statOe <= 1'b0; doneOe <= 1'b0;
      cfgOvrDisN <= 1'b1; reqOvrDisN <= 1'b1; statOvrDisN <= 1'b1; doneOvrDisN <= 1'b1;
      dataEn <= 1'b0; ctrlEn <= 1'b0; cfgOk <= 1'b0; errCode <= ERR_NONE;
    end else begin
      if (stb.clrResult) begin cfgOk <= 1'b0; errCode <= ERR_NONE; end
      if (stb.setup) begin
        ceN <= 1'b1; prReq <= 1'b0; reqOut <= 1'b1; statOe <= 1'b0; doneOe <= 1'b0;
        dataEn <= 1'b0; ctrlEn <= 1'b0;
        cfgOvrDisN <= 1'b0; reqOvrDisN <= 1'b0; statOvrDisN <= 1'b1; doneOvrDisN <= 1'b1;
      end
      if (stb.ceLow)   ceN <= 1'b0;
      if (stb.reqLow)  reqOut <= 1'b0;
      if (stb.reqHigh) reqOut <= 1'b1;
      if (stb.enPaths) begin dataEn <= 1'b1; ctrlEn <= 1'b1; end
      if (stb.relPins) begin
        dataEn <= 1'b0; ctrlEn <= 1'b0; cfgOvrDisN <= 1'b1; reqOvrDisN <= 1'b1; ceN <= 1'b1;
      end
      if (stb.finishOk) cfgOk <= 1'b1;
      if (stb.abort) begin errCode <= stb.code; dataEn <= 1'b0; ctrlEn <= 1'b0; end
    end
  end

  AST_ENABLE_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEn) |-> (reqOut && !ceN && ctrlEn)); // R7
  AST_PULSE_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqOut) |-> !ceN); // R5
  AST_SELECT_WITH_OVERRIDES: assert property (@(posedge clk) disable iff (!rstN)
    !ceN |-> (!cfgOvrDisN && !reqOvrDisN && statOvrDisN && doneOvrDisN)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(TMO_CYCLES)); // R9
endmodule

// File: rtl/ppcfg_seq.sv
module ppcfg_seq
  import ppcfg_pkg::*;
#(
  parameter int MSEL_W     = 3,
  parameter int CLK_KHZ    = 100000,
  parameter int TMO_CYCLES = CLK_KHZ * 1000,
  localparam int SYN_W     = MSEL_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MSEL_W-1:0] modeSel,
  input  logic              reqPinIn,
  input  logic              statPinIn,
  input  logic              donePinIn,
  input  logic              doneOeIn,
  input  logic              userModeIn,
  input  logic              dataFinished,
  output logic              ceN,
  output logic              prReq,
  output logic              reqOut,
  output logic              statOe,
  output logic              doneOe,
  output logic              cfgOvrDisN,
  output logic              reqOvrDisN,
  output logic              statOvrDisN,
  output logic              doneOvrDisN,
  output logic              dataEn,
  output logic              ctrlEn,
  output logic              busy,
  output logic              cfgOk,
  output logic [2:0]        errCode
);
  logic [SYN_W-1:0]  synOut;
  logic [MSEL_W-1:0] sMode;
  logic              sReq, sStat, sDone, sDoe, sUser, cntHit;
  strobe_t           stb;
  errCode_e          errQ;

  ppcfg_sync #(.W(SYN_W), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN),
    .d({modeSel, reqPinIn, statPinIn, donePinIn, doneOeIn, userModeIn}),
    .q(synOut)
  );
  assign {sMode, sReq, sStat, sDone, sDoe, sUser} = synOut;

  ppcfg_ctrl #(.MSEL_W(MSEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sMode(sMode), .sReq(sReq),
    .sStat(sStat), .sDone(sDone), .sDoe(sDoe), .sUser(sUser),
    .dataFin(dataFinished), .cntHit(cntHit), .stb(stb), .busy(busy)
  );

  ppcfg_dp #(.TMO_CYCLES(TMO_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cntHit(cntHit), .ceN(ceN),
    .prReq(prReq), .reqOut(reqOut), .statOe(statOe), .doneOe(doneOe),
    .cfgOvrDisN(cfgOvrDisN), .reqOvrDisN(reqOvrDisN),
    .statOvrDisN(statOvrDisN), .doneOvrDisN(doneOvrDisN),
    .dataEn(dataEn), .ctrlEn(ctrlEn), .cfgOk(cfgOk), .errCode(errQ)
  );
  assign errCode = errQ;

  AST_MODE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (errCode == ERR_MODE) |-> ($stable(reqOut) && $stable(ceN))); // R2
  AST_OK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    cfgOk |-> (ceN && !dataEn && !ctrlEn && cfgOvrDisN && reqOvrDisN)); // R10
endmodule

// File: tb/sim_ppcfg_seq.sv
`timescale 1ns/1ps
module sim_ppcfg_seq;
  localparam int MW  = 3;
  localparam int TMO = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [MW-1:0] modeSel = '0;
  logic reqPinIn = 1'b1, statPinIn = 1'b1, donePinIn = 1'b0, doneOeIn = 1'b1;
  logic userModeIn = 1'b0, dataFinished = 1'b0;
  logic ceN, prReq, reqOut, statOe, doneOe, cfgOvrDisN, reqOvrDisN, statOvrDisN;
  logic doneOvrDisN, dataEn, ctrlEn, busy, cfgOk;
  logic [2:0] errCode;

  always #2 clk = ~clk;

  ppcfg_seq #(.MSEL_W(MW), .TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel), .reqPinIn(reqPinIn),
    .statPinIn(statPinIn), .donePinIn(donePinIn), .doneOeIn(doneOeIn),
    .userModeIn(userModeIn), .dataFinished(dataFinished), .ceN(ceN), .prReq(prReq),
    .reqOut(reqOut), .statOe(statOe), .doneOe(doneOe), .cfgOvrDisN(cfgOvrDisN),
    .reqOvrDisN(reqOvrDisN), .statOvrDisN(statOvrDisN), .doneOvrDisN(doneOvrDisN),
    .dataEn(dataEn), .ctrlEn(ctrlEn), .busy(busy), .cfgOk(cfgOk), .errCode(errCode)
  );

  int total = 0, bad = 0, cycles = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // device emulator: status follows the request drive three cycles later
  logic holdReq = 1'b0, statKill = 1'b0, doneLvl = 1'b0, doeLvl = 1'b1, userLvl = 1'b0;
  logic [2:0] reqDly = 3'b111;
  logic sawReqLow = 1'b0;
  always @(negedge clk) begin
    reqDly     <= {reqDly[1:0], reqOut};
    reqPinIn   <= reqOut && !holdReq;
    statPinIn  <= reqDly[2] && !statKill;
    donePinIn  <= doneLvl;
    doneOeIn   <= doeLvl;
    userModeIn <= userLvl;
    if (rstN && !reqOut) sawReqLow <= 1'b1;
  end

  // behavioural reference model
  localparam int P_IDLE = 0, P_CHK = 1, P_WR1 = 2, P_SET = 3, P_CEL = 4, P_WR2 = 5,
                 P_RQL = 6, P_WSL = 7, P_RQH = 8, P_WSH = 9, P_CHD = 10, P_EN = 11,
                 P_WDT = 12, P_WCD = 13, P_WUM = 14, P_REL = 15, P_FIN = 16;
  int mPh = P_IDLE, mCnt = 0;
  int mErr = 0;
  bit mCeN = 1, mRq = 1, mDen = 0, mCen = 0, mCfgO = 1, mReqO = 1, mStO = 1, mDnO = 1, mOk = 0;
  bit [MW+4:0] hist[$];

  task automatic mAbort(input int c);
    mErr = c; mDen = 0; mCen = 0; mPh = P_IDLE; mCnt = 0;
  endtask
  task automatic mGo(input int p);
    mPh = p; mCnt = 0;
  endtask
  task automatic mTick();
    if (mCnt == TMO) mAbort(2); else mCnt++;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = P_IDLE; mCnt = 0; mErr = 0; mOk = 0;
      mCeN = 1; mRq = 1; mDen = 0; mCen = 0; mCfgO = 1; mReqO = 1; mStO = 1; mDnO = 1;
      hist = {'0, '0};
    end else begin
      bit [MW+4:0] s;
      bit [MW-1:0] sMode;
      bit sReq, sStat, sDone, sDoe, sUser;
      s = hist.pop_front();
      hist.push_back({modeSel, reqPinIn, statPinIn, donePinIn, doneOeIn, userModeIn});
      {sMode, sReq, sStat, sDone, sDoe, sUser} = s;
      case (mPh)
        P_IDLE: if (start) begin mPh = P_CHK; mOk = 0; mErr = 0; end
        P_CHK:  if (sMode[MW-1:1] != 0) mAbort(1); else mGo(P_WR1);
        P_WR1:  if (sReq && sStat) mGo(P_SET); else mTick();
        P_SET:  begin
          mCeN = 1; mRq = 1; mDen = 0; mCen = 0;
          mCfgO = 0; mReqO = 0; mStO = 1; mDnO = 1; mGo(P_CEL);
        end
        P_CEL:  begin mCeN = 0; mGo(P_WR2); end
        P_WR2:  if (sReq && sStat) mGo(P_RQL); else mTick();
        P_RQL:  begin mRq = 0; mGo(P_WSL); end
        P_WSL:  if (!sStat) mGo(P_RQH); else mTick();
        P_RQH:  begin mRq = 1; mGo(P_WSH); end
        P_WSH:  if (sStat) mGo(P_CHD); else mTick();
        P_CHD:  if (!sDone && sDoe) mGo(P_EN); else mAbort(3);
        P_EN:   begin mDen = 1; mCen = 1; mGo(P_WDT); end
        P_WDT:  if (dataFinished) mGo(P_WCD);
        P_WCD:  if (sDone) mGo(P_WUM); else if (!sStat) mAbort(4); else mTick();
        P_WUM:  if (sUser) mGo(P_REL); else mTick();
        P_REL:  begin mDen = 0; mCen = 0; mCfgO = 1; mReqO = 1; mCeN = 1; mGo(P_FIN); end
        default: if (sUser && sDone && sStat) begin mOk = 1; mGo(P_IDLE); end
                 else mAbort(5);
      endcase
    end
  end

  // per-cycle comparison against the model (R11 timing through the synchronizer)
  always @(negedge clk) begin
    if (rstN) begin
      bit [13:0] dutV, refV;
      dutV = {ceN, reqOut, dataEn, ctrlEn, cfgOvrDisN, reqOvrDisN, statOvrDisN,
              doneOvrDisN, busy, cfgOk, prReq, statOe, doneOe, 1'b0};
      refV = {mCeN, mRq, mDen, mCen, mCfgO, mReqO, mStO, mDnO, (mPh != P_IDLE), mOk,
              3'b000, 1'b0};
      chk(dutV == refV, "R11 per-cycle outputs", int'(dutV), int'(refV));
      chk(int'(errCode) == mErr, "R11 per-cycle errCode", int'(errCode), mErr);
    end
  end

  task automatic runCfg(input int modeV, input bit doeV, input bit hold, input bit killDone,
                        input bit giveUser, input bit killUser, input int expErr,
                        input bit expOk, input string tag);
    bit sawEn;
    sawEn = 0;
    @(negedge clk);
    modeSel = MW'(modeV); doeLvl = doeV; holdReq = hold;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (400) begin
      @(negedge clk);
      if (dataEn || !busy) break;
    end
    if (dataEn) begin
      sawEn = 1;
      if (tag == "pass") begin
        chk(!ceN && !cfgOvrDisN && !reqOvrDisN && statOvrDisN && doneOvrDisN,
            "R4 overrides while selected",
            int'({ceN, cfgOvrDisN, reqOvrDisN, statOvrDisN, doneOvrDisN}), 3);
        chk(ctrlEn, "R7 enables together", int'(ctrlEn), 1);
        chk(sawReqLow, "R5 request pulsed low", int'(sawReqLow), 1);
      end
      repeat (4) @(negedge clk);
      dataFinished = 1'b1;
      repeat (6) @(negedge clk);
      if (killDone) statKill = 1'b1;
      else begin
        doneLvl = 1'b1;
        repeat (6) @(negedge clk);
        if (giveUser) userLvl = 1'b1;
        if (killUser) statKill = 1'b1;
      end
    end
    repeat (400) begin
      @(negedge clk);
      if (!busy) break;
    end
    chk(int'(errCode) == expErr, {tag, " errCode"}, int'(errCode), expErr);
    chk(cfgOk == expOk, {tag, " cfgOk"}, int'(cfgOk), int'(expOk));
    chk(!dataEn && !ctrlEn, {tag, " R7 enables low after run"}, int'({dataEn, ctrlEn}), 0);
    if (!sawEn && expErr != 0)
      chk(1'b1, {tag, " no enable before failure"}, 0, 0);
    dataFinished = 1'b0; statKill = 1'b0; doneLvl = 1'b0; userLvl = 1'b0;
    holdReq = 1'b0; doeLvl = 1'b1; sawReqLow = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ceN, reqOut, dataEn, ctrlEn, prReq, statOe, doneOe} == 7'b1100000,
        "R1 reset pins", int'({ceN, reqOut, dataEn, ctrlEn, prReq, statOe, doneOe}), 96);
    chk({cfgOvrDisN, reqOvrDisN, statOvrDisN, doneOvrDisN} == 4'hF, "R1 reset overrides",
        int'({cfgOvrDisN, reqOvrDisN, statOvrDisN, doneOvrDisN}), 15);
    chk(!busy && !cfgOk && errCode == 0, "R1 reset status", int'({busy, cfgOk, errCode}), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    runCfg(0, 1, 0, 0, 1, 0, 0, 1, "pass");
    chk(ceN && cfgOvrDisN && reqOvrDisN, "R10 pins released",
        int'({ceN, cfgOvrDisN, reqOvrDisN}), 7);
    runCfg(2, 1, 0, 0, 1, 0, 1, 0, "R2 mode reject");
    chk(reqOut && ceN, "R2 no pin driven", int'({reqOut, ceN}), 3);
    runCfg(1, 1, 0, 0, 1, 0, 0, 1, "R2 mode1 accept");
    runCfg(0, 1, 1, 0, 1, 0, 2, 0, "R3 R9 held request timeout");
    chk(ceN, "R3 never selected", int'(ceN), 1);
    runCfg(0, 0, 0, 0, 1, 0, 3, 0, "R6 handshake");
    runCfg(0, 1, 0, 1, 1, 0, 4, 0, "R8 status low");
    runCfg(0, 1, 0, 0, 0, 0, 2, 0, "R9 user timeout");
    runCfg(0, 1, 0, 0, 1, 1, 5, 0, "R10 final check");
    runCfg(4, 1, 0, 0, 1, 0, 1, 0, "R2 high bit");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 60000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule